// File: doc/BRIEF.md
# Row-Based Program-Verify Sequencer

This block drives the programming of a nonvolatile word array. Given a start address, an end address and a stream of target words, it clears to 0 every bit that the target pattern marks as 0. Programming can only move a bit from 1 to 0, and a single pulse may not be enough to move it. The sequencer works on one row of `ROW_WORDS` consecutive words at a time. It first pulls the target words for that row span from an input stream into a local row buffer. It then makes repeated passes over the span. In each pass, for every word and for each byte lane in turn, it reads the word back under the verify-zeros reference. It builds a write mask in which only the still-unprogrammed target-zero bits of the selected lane are 0. It applies one timed program pulse only when that mask leaves something to do.

A pass that applies no pulse proves the row is programmed. The sequencer then moves to the next row, or finishes once the row that ends at the end address is complete. Each row has a budget of `MAX_PULSES` pulses. A row that would need one more pulse than the budget ends the job with a failure. Control and status pins are plain levels and single-cycle strobes. The target data arrives on a valid/ready stream: the source may hold `pat_valid` low at any time, and a word counts as taken only in a cycle where `pat_valid` and `pat_ready` are both high.

Top module: `prog_row_seq`

## Requirements
- R1: Out of reset `busy`, `done`, `fail`, `pat_ready`, `arr_rd` and `arr_pgm` are 0. A `start` pulse while idle, with `end_addr` not below `start_addr`, makes `busy` 1 from the next cycle until the cycle in which `done` or `fail` is 1; `busy` is 0 in that cycle.
- R2: `pat_ready` is 1 only while a row span is being loaded. Exactly one word is taken per address of the job, in ascending address order, and a cycle with `pat_valid` low takes nothing.
- R3: A row span runs from the current address to the lesser of the end address and the last address of its aligned `ROW_WORDS` block (the address with all low index bits set). No address outside [start_addr, end_addr] is ever pulsed.
- R4: Every pulse is preceded by a read (`arr_rd`) of the same word. In `arr_wdata`, a 0 bit means "program this bit". A bit is 0 there only if its target bit is 0 and the preceding read returned 1.
- R5: Each pulse covers one byte lane. All other lanes of `arr_wdata` are 8'hFF. Within a word the lanes are handled from lane 0 (bits 7:0) upward, each with its own read.
- R6: `arr_pgm` stays high for exactly `PULSE_CYC` consecutive cycles per pulse, and `arr_addr` and `arr_wdata` do not change while it is high.
- R7: A lane whose read shows no remaining bit to program gets no pulse.
- R8: Passes over a row repeat until a pass applies no pulse. At the end of the job every target-zero bit in the range reads 0, and the bits the target marks as 1 are left as they were.
- R9: If a row needs a pulse after `MAX_PULSES` pulses have already been applied to it, no further pulse is applied and the job ends with `fail`.
- R10: `done` and `fail` are never 1 together, and each lasts one cycle.
- R11: A `start` pulse while `busy` is 1 is ignored: the running job keeps its addresses and completes as if the pulse had not occurred.
- R12: A `start` with `end_addr` below `start_addr` produces `done` in the next cycle, with no word taken and no pulse applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (sampled while idle) |
| start_addr | input | ADDR_W | First word address of the job |
| end_addr | input | ADDR_W | Last word address of the job |
| pat_valid | input | 1 | Target word available on `pat_data` |
| pat_ready | output | 1 | Sequencer accepts a target word this cycle |
| pat_data | input | DATA_W | Target pattern word (0 bits are to be programmed) |
| arr_addr | output | ADDR_W | Array word address for read or pulse |
| arr_rd | output | 1 | Verify-zeros read request; data expected on `arr_rdata` in the next cycle |
| arr_rdata | input | DATA_W | Word returned by the array for the previous read |
| arr_pgm | output | 1 | Program pulse active |
| arr_wdata | output | DATA_W | Program mask; 0 bits receive the pulse |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle strobe: job completed |
| fail | output | 1 | One-cycle strobe: pulse budget of a row exceeded |

## Verification
The assertions assume that the array answers a read in the cycle after `arr_rd` and holds that value until the next read, that `ROW_WORDS` is a power of two, and that `DATA_W` is a whole number of bytes. The bench array model honours the one-cycle read latency. It applies a pulse only to the bits that the mask selects, and each bit needs a random number of pulses (one to three) before it reads 0. The stream source drops `pat_valid` at random, and the bench supplies words strictly in address order, so back-pressure and gaps are exercised without breaking the ordering the sequencer relies on. Addresses are kept inside the model's range, and a word on each side of every job is seeded with programmable bits to catch work done outside the range.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_READ,
    S_EVAL,
    S_PULSE,
    S_STEP,
    S_PASS,
    S_DONE,
    S_FAIL
  } seq_state_t;

endpackage

// File: rtl/prog_row_buf.sv
module prog_row_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);

  logic [DATA_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/prog_lane_mask.sv
module prog_lane_mask #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 1
) (
  input  logic [DATA_W-1:0] target,
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] mask,
  output logic              need
);

  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] pend;
    // a bit still needs work when the target wants 0 and the array still reads 1
    assign pend = ~target[8*g +: 8] & rdata[8*g +: 8];
    assign mask[8*g +: 8] = (lane == LANE_W'(g)) ? ~pend : 8'hFF;
  end

  assign need = ~&mask;

endmodule

// File: rtl/prog_pulse_timer.sv
module prog_pulse_timer #(
  parameter int PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic [CW-1:0] cnt;

  assign last = run && (cnt == CW'(PULSE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (last)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R6: the width counter never walks past the programmed pulse length
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(cnt) < PULSE_CYC));

  // R6: a pulse ends only after its last cycle
  a_r6_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> run);

endmodule

// File: rtl/prog_row_seq.sv
module prog_row_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int ROW_WORDS  = 32,
  parameter int MAX_PULSES = 24,
  parameter int PULSE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              pat_valid,
  output logic              pat_ready,
  input  logic [DATA_W-1:0] pat_data,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_rd,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_pgm,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  localparam int IDX_W  = $clog2(ROW_WORDS);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W  = $clog2(MAX_PULSES + 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
  localparam logic [CNT_W-1:0]  BUDGET    = CNT_W'(MAX_PULSES);

  seq_state_t        state;
  logic [ADDR_W-1:0] row_lo, row_hi, end_q, load_addr, cur;
  logic [LANE_W-1:0] lane;
  logic [CNT_W-1:0]  pcnt;
  logic              any_pulse;
  logic [DATA_W-1:0] wdata_q;

  logic              pat_fire;
  logic [DATA_W-1:0] tgt_word, lane_mask;
  logic              lane_need, pulse_last;

  // last address of the span that begins at a, clipped by the job end e
  function automatic logic [ADDR_W-1:0] span_end(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] e);
    logic [ADDR_W-1:0] blk_end;
    blk_end = a | ADDR_W'(ROW_WORDS - 1);
    return (e < blk_end) ? e : blk_end;
  endfunction

  assign pat_ready = (state == S_LOAD);
  assign pat_fire  = pat_valid && pat_ready;
  assign arr_rd    = (state == S_READ);
  assign arr_pgm   = (state == S_PULSE);
  assign arr_addr  = cur;
  assign arr_wdata = wdata_q;
  assign done      = (state == S_DONE);
  assign fail      = (state == S_FAIL);
  assign busy      = (state != S_IDLE) && (state != S_DONE) && (state != S_FAIL);

  prog_row_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (ROW_WORDS)
  ) u_buf (
    .clk     (clk),
    .wr_en   (pat_fire),
    .wr_idx  (load_addr[IDX_W-1:0]),
    .wr_data (pat_data),
    .rd_idx  (cur[IDX_W-1:0]),
    .rd_data (tgt_word)
  );

  prog_lane_mask #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_mask (
    .target (tgt_word),
    .rdata  (arr_rdata),
    .lane   (lane),
    .mask   (lane_mask),
    .need   (lane_need)
  );

  prog_pulse_timer #(
    .PULSE_CYC (PULSE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (arr_pgm),
    .last  (pulse_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      row_lo    <= '0;
      row_hi    <= '0;
      end_q     <= '0;
      load_addr <= '0;
      cur       <= '0;
      lane      <= '0;
      pcnt      <= '0;
      any_pulse <= 1'b0;
      wdata_q   <= '1;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            end_q <= end_addr;
            if (end_addr < start_addr) begin
              state <= S_DONE;
            end else begin
              row_lo    <= start_addr;
              load_addr <= start_addr;
              row_hi    <= span_end(start_addr, end_addr);
              state     <= S_LOAD;
            end
          end
        end

        S_LOAD: begin
          if (pat_fire) begin
            if (load_addr == row_hi) begin
              cur       <= row_lo;
              lane      <= '0;
              pcnt      <= '0;
              any_pulse <= 1'b0;
              state     <= S_READ;
            end else begin
              load_addr <= load_addr + 1'b1;
            end
          end
        end

        S_READ: state <= S_EVAL;

        S_EVAL: begin
          if (!lane_need) begin
            state <= S_STEP;
          end else if (pcnt == BUDGET) begin
            state <= S_FAIL;
          end else begin
            wdata_q   <= lane_mask;
            pcnt      <= pcnt + 1'b1;
            any_pulse <= 1'b1;
            state     <= S_PULSE;
          end
        end

        S_PULSE: begin
          if (pulse_last) begin
            wdata_q <= '1;
            state   <= S_STEP;
          end
        end

        S_STEP: begin
          if (lane != LAST_LANE) begin
            lane  <= lane + 1'b1;
            state <= S_READ;
          end else begin
            lane <= '0;
            if (cur == row_hi) begin
              state <= S_PASS;
            end else begin
              cur   <= cur + 1'b1;
              state <= S_READ;
            end
          end
        end

        S_PASS: begin
          if (any_pulse) begin
            any_pulse <= 1'b0;
            cur       <= row_lo;
            state     <= S_READ;
          end else if (row_hi == end_q) begin
            state <= S_DONE;
          end else begin
            row_lo    <= row_hi + 1'b1;
            load_addr <= row_hi + 1'b1;
            row_hi    <= span_end(row_hi + 1'b1, end_q);
            state     <= S_LOAD;
          end
        end

        S_DONE:  state <= S_IDLE;
        S_FAIL:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // lanes that a pulse touches, for the one-lane check
  logic [LANES-1:0] lane_hit;
  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign lane_hit[g] = (arr_wdata[8*g +: 8] != 8'hFF);
  end

  // R5: a pulse programs exactly one byte lane
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    arr_pgm |-> ($countones(lane_hit) == 1));

  // R6: address and mask hold still for the whole pulse
  a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_pgm && $past(arr_pgm)) |-> ($stable(arr_wdata) && $stable(arr_addr)));

  // R4: each pulse follows a read of the same word two cycles earlier
  a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_pgm) |-> ($past(arr_rd, 2) && $stable(arr_addr)));

  // R9: the per-row pulse count never passes its budget
  a_r9_budget: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pcnt) <= MAX_PULSES);

  // R10: the two end strobes are exclusive and one cycle long
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail));

  // R2: the stream is only accepted during a job
  a_r2_ready_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ready |-> busy);

  // R11: a start while busy leaves the latched end address alone
  a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(end_q));

  // R3: a span never extends past the job end
  a_r3_span: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (row_hi <= end_q));

endmodule

// File: tb/tb_prog_row_seq.sv
module tb_prog_row_seq;
  localparam int AW = 8, DW = 16, RW = 32, MAXP = 24, PW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, pat_valid = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [DW-1:0] pat_data = '0, arr_rdata = '0;
  logic          pat_ready, arr_rd, arr_pgm, busy, done, fail;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  prog_row_seq #(.ADDR_W(AW), .DATA_W(DW), .ROW_WORDS(RW),
                 .MAX_PULSES(MAXP), .PULSE_CYC(PW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_data(pat_data), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .arr_rdata(arr_rdata), .arr_pgm(arr_pgm), .arr_wdata(arr_wdata),
    .busy(busy), .done(done), .fail(fail));

  logic [DW-1:0] mem [256], tgt [256], orig [256];
  logic [31:0]   rem [256];
  int checks = 0, fails = 0;
  int pulses = 0, stub_err = 0, fed = 0, feed_n = 0, feed_base = 0;
  bit feed_en = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // array model: read data for the next cycle, per-bit pulse counting
  initial begin
    bit pgm_prev = 0;
    int plen = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wd = '0;
    forever begin
      @(negedge clk);
      if (arr_rd) arr_rdata = mem[arr_addr];
      if (arr_pgm) begin
        if (!pgm_prev) begin
          p_addr = arr_addr; p_wd = arr_wdata; plen = 1; pulses++;
          if (p_wd[15:8] != 8'hFF && p_wd[7:0] != 8'hFF) stub_err++;
          if (p_wd == 16'hFFFF) stub_err++;
          for (int b = 0; b < DW; b++) begin
            if (!p_wd[b]) begin
              if (!mem[p_addr][b] || tgt[p_addr][b]) stub_err++;
              else if (rem[p_addr][2*b +: 2] <= 2'd1) begin
                mem[p_addr][b] = 1'b0; rem[p_addr][2*b +: 2] = 2'd0;
              end else rem[p_addr][2*b +: 2] = rem[p_addr][2*b +: 2] - 2'd1;
            end
          end
        end else begin
          plen++;
          if (arr_addr != p_addr || arr_wdata != p_wd) stub_err++;
        end
      end else if (pgm_prev && plen != PW) stub_err++;
      pgm_prev = arr_pgm;
    end
  end

  // target stream source with random gaps
  initial begin
    bit rdy_q = 0;
    forever begin
      @(negedge clk);
      if (pat_valid && rdy_q) fed++;
      if (feed_en && fed < feed_n && ($urandom % 4) != 0) begin
        pat_valid = 1'b1;
        pat_data  = tgt[(feed_base + fed) & 255];
      end else pat_valid = 1'b0;
      rdy_q = pat_ready;
    end
  end

  // dens: 0 none, 1 sparse, 2 medium, 3 every bit with fixed hardness hmax
  task automatic setup(input int lo, input int hi, input int dens, input int hmax);
    for (int a = lo; a <= hi; a++) begin
      if (a >= 0 && a < 256) begin
        logic [DW-1:0] o, sp, t;
        logic [31:0] r;
        o = DW'($urandom);
        case (dens)
          0: sp = '0;
          1: sp = DW'($urandom & $urandom & $urandom);
          2: sp = DW'($urandom & $urandom);
          default: begin o = '1; sp = '1; end
        endcase
        t = ~((o & sp) | (~o & DW'($urandom)));
        r = '0;
        for (int b = 0; b < DW; b++)
          if (o[b] && !t[b])
            r[2*b +: 2] = (dens == 3) ? 2'(hmax) : 2'(1 + $urandom % hmax);
        mem[a] = o; orig[a] = o; tgt[a] = t; rem[a] = r;
      end
    end
  endtask

  function automatic int row_cost(input int lo, input int hi);
    int c = 0;
    for (int a = lo; a <= hi; a++)
      for (int l = 0; l < DW / 8; l++) begin
        int m = 0;
        for (int b = 8 * l; b < 8 * l + 8; b++)
          if (int'(rem[a][2*b +: 2]) > m) m = int'(rem[a][2*b +: 2]);
        c += m;
      end
    return c;
  endfunction

  task automatic run(input int s, input int e, input int dens, input int hmax,
                     input bit poke, input string tag);
    int lo, hi, tot, n;
    bit exp_fail, got_done, got_fail;
    int rlo, rhi;
    rlo = ((s < e) ? s : e) - 1;
    rhi = ((s < e) ? e : s) + 1;
    setup(rlo, rhi, dens, hmax);
    exp_fail = 0; tot = 0;
    if (e >= s) begin
      lo = s;
      forever begin
        int c;
        hi = ((lo | (RW - 1)) < e) ? (lo | (RW - 1)) : e;
        c = row_cost(lo, hi);
        if (c > MAXP) begin exp_fail = 1; tot += MAXP; break; end
        tot += c;
        if (hi == e) break;
        lo = hi + 1;
      end
    end
    @(negedge clk);
    fed = 0; pulses = 0; stub_err = 0; feed_base = s;
    feed_n = (e >= s) ? e - s + 1 : 0; feed_en = 1;
    start = 1'b1; start_addr = AW'(s); end_addr = AW'(e);
    @(negedge clk);
    start = 1'b0;
    if (e >= s) check(busy == 1'b1, {"R1 busy after start ", tag}, int'(busy), 1);
    n = 0;
    while (!(done || fail) && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 30) begin
        check(busy == 1'b1, {"R11 busy at poke ", tag}, int'(busy), 1);
        start = 1'b1; start_addr = '0; end_addr = '1;
      end
      if (poke && n == 31) begin
        start = 1'b0;
        check(busy == 1'b1, {"R11 busy after poke ", tag}, int'(busy), 1);
      end
    end
    got_done = done; got_fail = fail;
    check(busy == 1'b0, {"R1 busy low at end ", tag}, int'(busy), 0);
    check(got_fail == exp_fail && got_done == !exp_fail,
          {"R9 outcome ", tag}, int'(got_fail), int'(exp_fail));
    @(negedge clk);
    check(!done && !fail && !busy, {"R10 strobe single ", tag},
          int'(done) + int'(fail), 0);
    feed_en = 0;
    check(pulses == tot, {"R7 R8 pulse count ", tag}, pulses, tot);
    check(stub_err == 0, {"R4 R5 R6 pulse shape ", tag}, stub_err, 0);
    if (!exp_fail) begin
      int bad = 0;
      check(fed == feed_n, {"R2 words taken ", tag}, fed, feed_n);
      for (int a = s; a <= e; a++) if (mem[a] != (orig[a] & tgt[a])) bad++;
      check(bad == 0, {"R8 final contents ", tag}, bad, 0);
    end
    begin
      int bad = 0;
      for (int a = rlo; a <= rhi; a++)
        if (a >= 0 && a < 256 && (a < s || a > e) && mem[a] != orig[a]) bad++;
      check(bad == 0, {"R3 outside range untouched ", tag}, bad, 0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !pat_ready && !arr_rd && !arr_pgm,
          "R1 reset state", int'(busy) + int'(pat_ready) + int'(arr_pgm), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(5, 5, 2, 3, 0, "single word");
    run(20, 50, 1, 3, 0, "row crossing");
    run(40, 70, 0, 1, 0, "already programmed");
    run(100, 103, 3, 3, 0, "budget exact");
    run(110, 114, 3, 3, 0, "budget exceeded");
    run(10, 5, 1, 2, 0, "R12 end below start");
    check(fed == 0, "R12 no word taken", fed, 0);
    run(128, 160, 1, 2, 1, "R11 start while busy");
    run(250, 255, 2, 3, 0, "top of array");
    for (int j = 0; j < 20; j++) begin
      int s = 1 + $urandom % 200;
      int len = $urandom % 48;
      run(s, s + len, 1 + $urandom % 2, 1 + $urandom % 3, 0, "random");
    end
    finish_run();
  end

endmodule